// File: doc/BRIEF.md
# Dual CAN Clock Prescaler Control

This block holds one 8-bit control register that sets the time-quantum clock for two CAN channels. Each nibble belongs to one channel. The lower three bits of a nibble choose a power-of-two division of the source clock, and the top bit puts that channel's CPU interface to sleep. From each selection the block makes a one-cycle clock-enable pulse that the CAN protocol engine uses to advance, so every engine runs on the single source clock.

Writes are accepted only when a separate protect-enable input is high. Each channel's CAN controller reports two status bits: whether it is in reset/initialization mode and whether it is in sleep mode. A divider change is taken only while that channel is in reset mode. The interface-sleep bit can be set only after that channel's controller is already asleep. Divider codes outside the allowed set are refused field by field, and the rest of the same write still takes effect.

Top module: `can_psc_ctrl`

## Requirements
- R1: After reset the register reads 0x00, and both clock enables are high on every cycle.
- R2: The register changes only on a cycle with both `bus_wr_en` and `wr_unlock` high. On any other cycle it holds its value.
- R3: A write updates channel i's divide field (bits 2:0 for channel 0, bits 6:4 for channel 1) only if `ch_init_mode[i]` is 1 in that cycle. Otherwise the field keeps its old value.
- R4: Divide code c (0 through 4) makes `can_clk_en[i]` pulse once every 2^c source cycles. Code 0 gives a pulse on every cycle.
- R5: A written divide code of 5, 6 or 7 leaves that field unchanged. The other fields in the same write are still applied.
- R6: Interface-sleep bit i (bit 3 for channel 0, bit 7 for channel 1) becomes 1 only when a write sets it while `ch_sleep_mode[i]` is 1. Writing 0 to it clears it in any state.
- R7: When the divide field changes, that channel's counter restarts. The first enable pulse at the new rate comes 2^c cycles after the write's clock edge.
- R8: `can_clk_en[i]` stays low while interface-sleep bit i is 1, and `if_sleep[i]` shows that bit.
- R9: `reg_rdata` always shows the current register contents, using the bit layout given in R3 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| wr_unlock | input | 1 | Protect enable; writes count only while high |
| ch_init_mode | input | 2 | Per-channel reset/initialization mode status |
| ch_sleep_mode | input | 2 | Per-channel controller sleep status |
| reg_rdata | output | 8 | Current register contents |
| can_clk_en | output | 2 | Per-channel prescaled clock-enable pulse |
| if_sleep | output | 2 | Per-channel CPU-interface sleep |

## Verification
A write is applied at the first rising edge that samples it. The register, `reg_rdata` and `if_sleep` therefore show the result one cycle after the strobe. After a divider change, the first enable pulse comes exactly 2^c cycles after that edge. The bench drives inputs on falling edges and lets its reference model step on each rising edge using the same sampled inputs. On every falling edge it compares all outputs with the model. Directed checks add pulse counts over windows that are whole multiples of the period, so the result does not depend on the counter's phase. They also count falling edges from a divider write to the first pulse.

// File: rtl/can_psc_pkg.sv
package can_psc_pkg;
  localparam int NUM_CH   = 2;
  localparam int SEL_W    = 3;
  localparam int NIB_W    = SEL_W + 1;
  localparam int REG_W    = NUM_CH * NIB_W;
  localparam int MAX_CODE = 4;
  localparam int CNT_W    = MAX_CODE;

  // Divide code is legal only up to MAX_CODE.
  function automatic logic code_ok(input logic [SEL_W-1:0] code);
    return code <= SEL_W'(MAX_CODE);
  endfunction

  // Final count value of one period: 2^code - 1.
  function automatic logic [CNT_W-1:0] last_count(input logic [SEL_W-1:0] code);
    logic [31:0] p;
    p = (32'd1 << code) - 32'd1;
    return p[CNT_W-1:0];
  endfunction
endpackage

// File: rtl/can_psc_reg.sv
module can_psc_reg
  import can_psc_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [REG_W-1:0]              wdata,
  input  logic                          unlock,
  input  logic [NUM_CH-1:0]             init_mode,
  input  logic [NUM_CH-1:0]             sleep_mode,
  output logic [NUM_CH-1:0][SEL_W-1:0]  div_sel,
  output logic [NUM_CH-1:0]             div_load,
  output logic [NUM_CH-1:0]             slp_q,
  output logic [REG_W-1:0]              rdata
);
  logic wr_accept;
  assign wr_accept = wr_en & unlock;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [SEL_W-1:0] div_q;
    logic             slp_r;
    logic [SEL_W-1:0] wr_code;
    logic             wr_slp;
    logic             div_upd;
    logic             div_rejected;
    logic             slp_set_req;
    logic             slp_set_blocked;
    logic             slp_clr;

    assign wr_code         = wdata[i*NIB_W +: SEL_W];
    assign wr_slp          = wdata[i*NIB_W + SEL_W];
    assign div_rejected    = wr_accept & (~init_mode[i] | ~code_ok(wr_code));
    assign div_upd         = wr_accept & ~div_rejected & (wr_code != div_q);
    assign slp_set_req     = wr_accept & wr_slp;
    assign slp_set_blocked = slp_set_req & ~sleep_mode[i];
    assign slp_clr         = wr_accept & ~wr_slp;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        div_q <= '0;
        slp_r <= 1'b0;
      end else begin
        if (div_upd) div_q <= wr_code;
        if (slp_clr) slp_r <= 1'b0;
        else if (slp_set_req && !slp_set_blocked) slp_r <= 1'b1;
      end
    end

    assign div_sel[i]                    = div_q;
    assign div_load[i]                   = div_upd;
    assign slp_q[i]                      = slp_r;
    assign rdata[i*NIB_W +: SEL_W]       = div_q;
    assign rdata[i*NIB_W + SEL_W]        = slp_r;
  end
endmodule

// File: rtl/can_psc_div.sv
module can_psc_div
  import can_psc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             load,
  input  logic             gate,
  output logic             clk_en,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  assign last = last_count(sel);
  assign wrap = (cnt >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (load)  cnt <= '0;
    else if (wrap)  cnt <= '0;
    else            cnt <= cnt + CNT_W'(1);
  end

  assign clk_en = wrap & ~gate;
endmodule

// File: rtl/can_psc_ctrl.sv
module can_psc_ctrl
  import can_psc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              wr_unlock,
  input  logic [NUM_CH-1:0] ch_init_mode,
  input  logic [NUM_CH-1:0] ch_sleep_mode,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [NUM_CH-1:0] can_clk_en,
  output logic [NUM_CH-1:0] if_sleep
);
  logic [NUM_CH-1:0][SEL_W-1:0] div_sel;
  logic [NUM_CH-1:0]            div_load;
  logic [NUM_CH-1:0]            slp_q;
  logic [NUM_CH-1:0]            div_wrap;

  can_psc_reg u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (bus_wr_en),
    .wdata      (bus_wdata),
    .unlock     (wr_unlock),
    .init_mode  (ch_init_mode),
    .sleep_mode (ch_sleep_mode),
    .div_sel    (div_sel),
    .div_load   (div_load),
    .slp_q      (slp_q),
    .rdata      (reg_rdata)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_psc
    can_psc_div u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (div_sel[i]),
      .load   (div_load[i]),
      .gate   (slp_q[i]),
      .clk_en (can_clk_en[i]),
      .wrap   (div_wrap[i])
    );
  end

  assign if_sleep = slp_q;
endmodule

// File: rtl/can_psc_chk.sv
module can_psc_chk
  import can_psc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr_en,
  input logic              wr_unlock,
  input logic [NUM_CH-1:0] ch_init_mode,
  input logic [NUM_CH-1:0] ch_sleep_mode,
  input logic [REG_W-1:0]  reg_rdata,
  input logic [NUM_CH-1:0] can_clk_en,
  input logic [NUM_CH-1:0] if_sleep
);
  AST_RESET_CLEAR: assert property (@(posedge clk) $rose(rst_n) |-> reg_rdata == '0); // R1
  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr_en && wr_unlock) |=> $stable(reg_rdata)); // R2

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_init_mode[i] |=> $stable(reg_rdata[i*NIB_W +: SEL_W])); // R3
    AST_DIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[i*NIB_W +: SEL_W] <= SEL_W'(MAX_CODE)); // R5
    AST_DIV1_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[i*NIB_W +: SEL_W] == '0 && !if_sleep[i]) |-> can_clk_en[i]); // R4
    AST_SLEEP_SET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(if_sleep[i]) |-> $past(ch_sleep_mode[i])); // R6
    AST_SLEEP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      if_sleep[i] |-> !can_clk_en[i]); // R8
    AST_SLEEP_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
      if_sleep[i] == reg_rdata[i*NIB_W + SEL_W]); // R9
  end
endmodule

bind can_psc_ctrl can_psc_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_wr_en     (bus_wr_en),
  .wr_unlock     (wr_unlock),
  .ch_init_mode  (ch_init_mode),
  .ch_sleep_mode (ch_sleep_mode),
  .reg_rdata     (reg_rdata),
  .can_clk_en    (can_clk_en),
  .if_sleep      (if_sleep)
);

// File: tb/can_psc_ctrl_bench.sv
`timescale 1ns/1ps
module can_psc_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr_en = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic       wr_unlock = 1'b0;
  logic [1:0] ch_init_mode = 2'b00;
  logic [1:0] ch_sleep_mode = 2'b00;
  logic [7:0] reg_rdata;
  logic [1:0] can_clk_en;
  logic [1:0] if_sleep;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int m_div [2];
  int m_slp [2];
  int m_cnt [2];

  always #2 clk = ~clk;

  can_psc_ctrl u_can_psc_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata),
    .wr_unlock(wr_unlock), .ch_init_mode(ch_init_mode), .ch_sleep_mode(ch_sleep_mode),
    .reg_rdata(reg_rdata), .can_clk_en(can_clk_en), .if_sleep(if_sleep)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: steps on each rising edge with the inputs driven at the falling edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int ch = 0; ch < 2; ch++) begin
        m_div[ch] = 0; m_slp[ch] = 0; m_cnt[ch] = 0;
      end
    end else begin
      for (int ch = 0; ch < 2; ch++) begin
        int last, f, s;
        bit ld;
        last = (1 << m_div[ch]) - 1;
        ld = 1'b0;
        if (bus_wr_en && wr_unlock) begin
          f = (bus_wdata >> (4*ch)) & 7;
          s = (bus_wdata >> (4*ch + 3)) & 1;
          if (ch_init_mode[ch] && f <= 4 && f != m_div[ch]) begin
            m_div[ch] = f; ld = 1'b1;
          end
          if (s == 0) m_slp[ch] = 0;
          else if (ch_sleep_mode[ch]) m_slp[ch] = 1;
        end
        if (ld) m_cnt[ch] = 0;
        else if (m_cnt[ch] == last) m_cnt[ch] = 0;
        else m_cnt[ch] = m_cnt[ch] + 1;
      end
    end
  end

  // Every-cycle comparison against the model.
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      for (int ch = 0; ch < 2; ch++) begin
        int exp_en;
        exp_en = (m_cnt[ch] == (1 << m_div[ch]) - 1 && m_slp[ch] == 0) ? 1 : 0;
        check("R4 clock enable", can_clk_en[ch], exp_en);
        check("R3 divide field", (reg_rdata >> (4*ch)) & 7, m_div[ch]);
        check("R6 sleep bit", if_sleep[ch], m_slp[ch]);
      end
      check("R9 read data", reg_rdata, m_div[0] | (m_slp[0] << 3) | (m_div[1] << 4) | (m_slp[1] << 7));
    end
  end

  task automatic write_reg(input logic [7:0] d, input logic unl);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_wdata = d; wr_unlock = unl;
    @(negedge clk);
    bus_wr_en = 1'b0; wr_unlock = 1'b0;
  endtask

  task automatic count_pulses(input int ch, input int n, output int cnt);
    cnt = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (can_clk_en[ch]) cnt++;
    end
  endtask

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset value", reg_rdata, 8'h00);
    count_pulses(0, 8, n); check("R1 ch0 undivided", n, 8);
    count_pulses(1, 8, n); check("R1 ch1 undivided", n, 8);

    ch_init_mode = 2'b11;
    write_reg(8'h33, 1'b0);
    check("R2 locked write ignored", reg_rdata, 8'h00);
    @(negedge clk); bus_wdata = 8'h44; wr_unlock = 1'b1;
    @(negedge clk); wr_unlock = 1'b0;
    check("R2 no strobe ignored", reg_rdata, 8'h00);

    ch_init_mode = 2'b01;
    write_reg(8'h21, 1'b1);
    check("R3 only ch0 in reset mode", reg_rdata, 8'h01);

    ch_init_mode = 2'b11;
    write_reg(8'h42, 1'b1);
    check("R9 both fields", reg_rdata, 8'h42);
    count_pulses(0, 64, n); check("R4 ch0 divide by 4", n, 16);
    count_pulses(1, 64, n); check("R4 ch1 divide by 16", n, 4);

    write_reg(8'h36, 1'b1);
    check("R5 reserved code refused, other field applied", reg_rdata, 8'h32);
    write_reg(8'h77, 1'b1);
    check("R5 both reserved", reg_rdata, 8'h32);

    // R7: first pulse 8 cycles after the accepting edge for divide by 8.
    @(negedge clk);
    bus_wr_en = 1'b1; bus_wdata = 8'h33; wr_unlock = 1'b1;
    n = 0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      bus_wr_en = 1'b0; wr_unlock = 1'b0;
      if (can_clk_en[0] && n == 0) n = k;
    end
    check("R7 restart delay", n, 8);

    write_reg(8'h3B, 1'b1);
    check("R6 set blocked while awake", reg_rdata, 8'h33);
    ch_sleep_mode = 2'b01;
    write_reg(8'h3B, 1'b1);
    check("R6 set while asleep", reg_rdata, 8'h3B);
    check("R8 if_sleep output", if_sleep, 2'b01);
    count_pulses(0, 64, n); check("R8 gated enable", n, 0);
    ch_sleep_mode = 2'b00;
    write_reg(8'h33, 1'b1);
    check("R6 clear always", reg_rdata, 8'h33);

    write_reg(8'h30, 1'b1);
    count_pulses(0, 16, n); check("R4 code 0 every cycle", n, 16);
    count_pulses(1, 64, n); check("R4 ch1 divide by 8", n, 8);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule